// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between a processor's execute stage and a 32-bit word-wide synchronous data memory. For each memory request it forms the effective address from a base register value and a signed 16-bit displacement. It then drives the word address, a per-byte write enable and the write data toward the memory. When the read word comes back one cycle later, it extracts the load result from it.

Bytes are numbered big-endian inside each word. The byte at address offset 0 is the most significant byte, bits 31:24. Word accesses must be aligned on a 4-byte boundary. A misaligned word access is reported on a flag and no memory access is made for it. Byte accesses can use any address.

The request side is purely combinational, so it acts in the same cycle as the request. The load side holds one register stage that matches the memory's one-cycle read latency.

Top module: `lsu_byte_lane`

## Requirements
- R1: The effective address is `base` plus the 16-bit `offset` sign-extended to 32 bits, wrapping modulo 2^32. `mem_word_addr` carries effective-address bits 31:2, and effective-address bits 1:0 select the byte lane.
- R2: Opcode 35 is load word, 43 is store word, 32 is load byte and 40 is store byte. With any other opcode, or with `req_valid` low, `mem_be` is 0, `mem_re` is 0 and no load result is produced.
- R3: An aligned store word drives `mem_be` = 4'b1111 and `mem_wdata` = `store_data`.
- R4: A store byte drives `mem_wdata` with bits 7:0 of `store_data` copied into all four bytes. It sets exactly one bit of `mem_be`: for lane k = effective-address bits 1:0, bit 3-k is set, and `mem_be[3]` covers `mem_wdata[31:24]`.
- R5: For a load word accepted in cycle N, `load_valid` is high in cycle N+1 and `load_data` equals `mem_rdata` of that cycle.
- R6: For a load byte at lane k, `load_data` in cycle N+1 is `mem_rdata[31-8k:24-8k]` sign-extended to 32 bits.
- R7: A word access with nonzero effective-address bits 1:0 raises `misalign` in the request cycle. It forces `mem_be` to 0 and `mem_re` to 0, and produces no `load_valid`. Byte accesses never raise `misalign`.
- R8: During and right after reset, `load_valid` is 0.
- R9: `mem_re` is high in the request cycle for accepted loads only and is never high together with a nonzero `mem_be`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| opcode | input | 6 | Access opcode |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Register value to store |
| mem_rdata | input | 32 | Read word from memory, one cycle after `mem_re` |
| mem_word_addr | output | 30 | Word address to memory |
| mem_re | output | 1 | Memory read strobe |
| mem_be | output | 4 | Byte write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-aligned write data |
| misalign | output | 1 | Misaligned word access flag |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extracted load result |

## Verification
The assertions check the following on every cycle: that a store byte enables exactly one lane, that an aligned store word enables all four, that a misaligned word access never writes or reads, that read and write are never driven together, and that every `load_valid` follows a read strobe. Only the bench's scenarios can show that the right lane is chosen for each address and that the displacement is sign-extended across wraparound. The same holds for the replicated write data and for the sign extension of loaded bytes, including the pairing of each load with its own read word when loads come back to back.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LD_BYTE = 6'd32;
  localparam logic [OPC_W-1:0] OPC_LD_WORD = 6'd35;
  localparam logic [OPC_W-1:0] OPC_ST_BYTE = 6'd40;
  localparam logic [OPC_W-1:0] OPC_ST_WORD = 6'd43;

  typedef struct packed {
    logic known;
    logic is_load;
    logic is_word;
  } acc_kind_t;

  function automatic acc_kind_t decode_opc(input logic [OPC_W-1:0] opc);
    acc_kind_t k;
    k = '0;
    unique case (opc)
      OPC_LD_BYTE: k = '{known: 1'b1, is_load: 1'b1, is_word: 1'b0};
      OPC_LD_WORD: k = '{known: 1'b1, is_load: 1'b1, is_word: 1'b1};
      OPC_ST_BYTE: k = '{known: 1'b1, is_load: 1'b0, is_word: 1'b0};
      OPC_ST_WORD: k = '{known: 1'b1, is_load: 1'b0, is_word: 1'b1};
      default:     k = '0;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]        base,
  input  logic [OFF_W-1:0]         offset,
  input  logic                     word_acc,
  output logic [DATA_W-LANE_W-1:0] word_addr,
  output logic [LANE_W-1:0]        lane,
  output logic                     unaligned
);
  logic [DATA_W-1:0] disp_ext;
  logic [DATA_W-1:0] eff_addr;

  always_comb begin
    disp_ext  = {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};
    eff_addr  = base + disp_ext;
    word_addr = eff_addr[DATA_W-1:LANE_W];
    lane      = eff_addr[LANE_W-1:0];
    unaligned = word_acc && (lane != '0);
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] store_data,
  input  logic [LANE_W-1:0] lane,
  input  logic              word_acc,
  input  logic              do_store,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  // Lane i is address offset i; big-endian puts it at the top of the word,
  // which is enable bit LANES-1-i.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      be[LANES-1-i] = do_store && (word_acc || (lane == LANE_W'(i)));
      wdata[DATA_W-1-8*i -: 8] = word_acc ? store_data[DATA_W-1-8*i -: 8]
                                          : store_data[7:0];
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANE_W-1:0] lane,
  input  logic              byte_acc,
  output logic [DATA_W-1:0] result
);
  logic [7:0] lane_byte [LANES];
  logic [7:0] picked;

  for (genvar i = 0; i < LANES; i++) begin : g_pick
    assign lane_byte[i] = rdata[DATA_W-1-8*i -: 8];
  end

  always_comb begin
    picked = lane_byte[lane];
    result = byte_acc ? {{(DATA_W-8){picked[7]}}, picked} : rdata;
  end
endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int WA_W   = DATA_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] store_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [WA_W-1:0]   mem_word_addr,
  output logic              mem_re,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              misalign,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data
);
  acc_kind_t         kind;
  logic              acc_ok;
  logic [LANE_W-1:0] lane;
  logic              unaligned;
  logic              do_store;

  // Load return stage
  logic              pend_q, pend_d;
  logic              byte_q, byte_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              cap_en;

  always_comb begin
    kind     = decode_opc(opcode);
    acc_ok   = req_valid && kind.known;
    misalign = acc_ok && unaligned;
    mem_re   = acc_ok && kind.is_load && !unaligned;
    do_store = acc_ok && !kind.is_load && !unaligned;
  end

  lsu_addr_gen #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_addr (
    .base      (base),
    .offset    (offset),
    .word_acc  (kind.is_word),
    .word_addr (mem_word_addr),
    .lane      (lane),
    .unaligned (unaligned)
  );

  lsu_store_lane #(.DATA_W(DATA_W)) u_store (
    .store_data (store_data),
    .lane       (lane),
    .word_acc   (kind.is_word),
    .do_store   (do_store),
    .be         (mem_be),
    .wdata      (mem_wdata)
  );

  // Next state
  always_comb begin
    cap_en = mem_re;
    pend_d = mem_re;
    byte_d = byte_q;
    lane_d = lane_q;
    if (cap_en) begin
      byte_d = !kind.is_word;
      lane_d = lane;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      byte_q <= 1'b0;
      lane_q <= '0;
    end else begin
      pend_q <= pend_d;
      byte_q <= byte_d;
      lane_q <= lane_d;
    end
  end

  assign load_valid = pend_q;

  lsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .rdata    (mem_rdata),
    .lane     (lane_q),
    .byte_acc (byte_q),
    .result   (load_data)
  );

  // Checks
  assert_byte_store_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == OPC_ST_BYTE) |-> ($countones(mem_be) == 1));

  assert_word_store_all_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == OPC_ST_WORD && !misalign) |-> (&mem_be));

  assert_misalign_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == '0 && !mem_re));

  assert_read_write_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_be) |-> !mem_re);

  assert_load_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(mem_re));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_be == '0 && !mem_re && !misalign));
endmodule

// File: tb/test_lsu_byte_lane.sv
module test_lsu_byte_lane;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] base = '0;
  logic [15:0] offset = '0;
  logic [31:0] store_data = '0;
  logic [31:0] mem_rdata = '0;
  logic [29:0] mem_word_addr;
  logic        mem_re;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        misalign;
  logic        load_valid;
  logic [31:0] load_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  lsu_byte_lane i_lsu_byte_lane (
    .clk, .rst_n, .req_valid, .opcode, .base, .offset, .store_data,
    .mem_rdata, .mem_word_addr, .mem_re, .mem_be, .mem_wdata,
    .misalign, .load_valid, .load_data
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one request, checks the request side, queues the load result.
  task automatic drive(input logic [5:0] opc, input logic [31:0] b, input logic [15:0] off,
                       input logic [31:0] sd, input logic [31:0] rd);
    logic [31:0] ea;
    logic [1:0]  k;
    logic        known, ld, wd, mis;
    logic [7:0]  by;
    @(negedge clk);
    req_valid = 1'b1; opcode = opc; base = b; offset = off; store_data = sd;
    mem_rdata = rd;
    ea    = b + {{16{off[15]}}, off};
    k     = ea[1:0];
    known = (opc == 6'd32) || (opc == 6'd35) || (opc == 6'd40) || (opc == 6'd43);
    ld    = (opc == 6'd32) || (opc == 6'd35);
    wd    = (opc == 6'd35) || (opc == 6'd43);
    mis   = known && wd && (k != 2'd0);
    #2;
    if (known) check("R1 word address", {2'b00, mem_word_addr}, {2'b00, ea[31:2]});
    check("R7 misalign flag", {31'd0, misalign}, {31'd0, mis});
    check("R9 read strobe", {31'd0, mem_re}, {31'd0, known && ld && !mis});
    if (!known || ld || mis)
      check("R2/R7 no write", {28'd0, mem_be}, 32'd0);
    else if (wd) begin
      check("R3 word mask", {28'd0, mem_be}, 32'hF);
      check("R3 word data", mem_wdata, sd);
    end else begin
      check("R4 byte mask", {28'd0, mem_be}, {28'd0, 4'b1000 >> k});
      check("R4 byte data", mem_wdata, {4{sd[7:0]}});
    end
    if (known && ld && !mis) begin
      by = rd[31 - 8*k -: 8];
      exp_q.push_back(wd ? rd : {{24{by[7]}}, by});
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; opcode = '0; mem_rdata = 32'hDEAD_BEEF;
    end
  endtask

  // Monitor: pops expected load results when the design presents them.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && load_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7/R2 unexpected load_valid: actual=1 expected=0");
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check("R5/R6 load data", load_data, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset load_valid", {31'd0, load_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset load_valid", {31'd0, load_valid}, 32'd0);

    // R1/R5 word loads, positive and negative displacement, wrap
    drive(6'd35, 32'h0000_1000, 16'h0008, 32'h0, 32'h1234_5678);
    drive(6'd35, 32'h0000_1000, 16'hFFFC, 32'h0, 32'h89AB_CDEF);
    drive(6'd35, 32'h0000_0000, 16'hFFFC, 32'h0, 32'h0BAD_F00D);
    idle(2);
    // R3 word store
    drive(6'd43, 32'h1000_0000, 16'h0010, 32'hCAFE_BABE, 32'h0);
    // R4 byte stores on all lanes
    for (int i = 0; i < 4; i++)
      drive(6'd40, 32'h2000_0000, 16'(i), 32'h1234_56A5, 32'h0);
    // R6 byte loads on all lanes, mixed signs, back to back
    for (int i = 0; i < 4; i++)
      drive(6'd32, 32'h3000_0003, 16'(i + 1), 32'h0, 32'h7F80_01FE);
    drive(6'd32, 32'h3000_0001, 16'hFFFF, 32'h0, 32'h8123_4567);
    idle(2);
    // R7 misaligned word accesses
    drive(6'd35, 32'h4000_0000, 16'h0002, 32'h0, 32'h1111_1111);
    drive(6'd43, 32'h4000_0001, 16'h0000, 32'h5555_5555, 32'h0);
    drive(6'd35, 32'h4000_0000, 16'h0003, 32'h0, 32'h2222_2222);
    idle(2);
    // R2 unknown opcodes
    drive(6'd0,  32'h5000_0000, 16'h0000, 32'hFFFF_FFFF, 32'h0);
    drive(6'd34, 32'h5000_0000, 16'h0004, 32'hFFFF_FFFF, 32'h0);
    idle(3);
    check("R5 all loads returned", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule